// File: doc/BRIEF.md
# Predictive Dead-Time Controller

This block turns a single PWM request into two mutually exclusive gate enables for a synchronous buck power stage: one for the main (high-side) switch and one for the synchronous rectifier (low-side) switch. Between the two conduction phases it always inserts a dead window in which both enables are low. There are two kinds of window: main-off to rectifier-on, and rectifier-off to main-on. Each has its own length.

Each window length is held in a small saturating up/down register and counted in clock ticks. While a window is open, a one-bit comparator input reports whether the rectifier body diode conducted. When the window closes, its register steps down by one if conduction was seen and up by one if it was not. The new value sets the length of the next window of the same kind. The loop therefore shortens each dead time until the diode just stops conducting, and keeps backing off toward safety whenever it sees no conduction. Software sees no timing directly; the block simply tracks the power stage.

Top module: `dt_predictive_ctrl`

## Requirements
- R1: After reset both enables are low and both delay settings are at their maximum (15 for the default 4-bit width), so the first window of each kind lasts BASE_TICKS + 15·STEP_TICKS cycles (16 cycles at the defaults).
- R2: While `en` is low, both enables are low from the next clock edge onward. A dead window cut short by `en` falling leaves that window's delay setting unchanged.
- R3: `hs_on` and `ls_on` are never high in the same cycle, including at the minimum delay setting.
- R4: After `pwm_req` is sampled low while `hs_on` is high, `hs_on` falls at that edge, and `ls_on` rises exactly BASE_TICKS + d_hl·STEP_TICKS edges later, where d_hl is the current main-off setting.
- R5: After `pwm_req` is sampled high while `ls_on` is high, `ls_on` falls at that edge, and `hs_on` rises exactly BASE_TICKS + d_lh·STEP_TICKS edges later, where d_lh is the current rectifier-off setting.
- R6: If `diode_sense` is sampled high on any edge inside a dead window (the window's edges after its opening edge, up to and including the closing edge), that window's setting is one lower for its next occurrence.
- R7: If `diode_sense` is never sampled high inside a dead window, that window's setting is one higher for its next occurrence.
- R8: Each setting saturates at 0 and at its maximum with no wrap-around. At setting 0 the window is still BASE_TICKS cycles long (1 at the defaults).
- R9: A window's outcome changes only its own setting; the other setting is left as it was.
- R10: From the disabled state, the first edge with `en` high turns on directly the switch selected by `pwm_req` (high selects the main switch). `pwm_req` is acted on only while a switch is on: a dead window, once opened, always completes and is followed by at least one on cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; dead windows are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces both gate enables low |
| pwm_req | input | 1 | PWM request: high asks for the main switch, low for the rectifier |
| diode_sense | input | 1 | High when the rectifier body diode is seen conducting |
| hs_on | output | 1 | Main (high-side) switch gate enable |
| ls_on | output | 1 | Rectifier (low-side) switch gate enable |

## Verification
The bench drives the main-off setting all the way down to 0 while leaving the other setting at its ceiling. A design that wrapped around would jump from the shortest window straight to the longest, and one that shared state between the two settings would shrink the wrong window. It also pushes both settings against their ceiling and floor, where an off-by-one in the tick count, or a missing minimum window, would show up as a gap of the wrong length or as both enables high together. It drops `en` in the middle of a window with the diode flagged, to catch a design that commits a half-observed outcome, and it toggles the request back inside a window, to catch a design that aborts the window or skips the one-cycle rectifier pulse.

// File: rtl/dt_pkg.sv
package dt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_HS   = 3'd1,
      ST_HL   = 3'd2,
      ST_LS   = 3'd3,
      ST_LH   = 3'd4
   } dt_state_e;

   localparam int WIN_HL  = 0;
   localparam int WIN_LH  = 1;
   localparam int NUM_WIN = 2;

endpackage

// File: rtl/dt_delay_reg.sv
module dt_delay_reg #(
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic             hit,
   output logic [DLY_W-1:0] val
);

   localparam logic [DLY_W-1:0] DLY_MAX = {DLY_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val <= DLY_MAX;
      end else if (upd) begin
         if (hit) begin
            if (val != '0) val <= val - 1'b1;
         end else begin
            if (val != DLY_MAX) val <= val + 1'b1;
         end
      end
   end

   // R8
   floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd && hit && val == '0 |=> val == '0);

   // R8
   ceil_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd && !hit && val == DLY_MAX |=> val == DLY_MAX);

   // R6
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd && hit && val != '0 |=> val == $past(val) - 1'b1);

   // R7
   step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd && !hit && val != DLY_MAX |=> val == $past(val) + 1'b1);

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(val));

endmodule

// File: rtl/dt_window_timer.sv
module dt_window_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   // R4
   tick_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load && !done |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/dt_predictive_ctrl.sv
module dt_predictive_ctrl #(
   parameter int DLY_W      = 4,
   parameter int BASE_TICKS = 1,
   parameter int STEP_TICKS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic pwm_req,
   input  logic diode_sense,
   output logic hs_on,
   output logic ls_on
);
   import dt_pkg::*;

   localparam int DLY_MAX = (1 << DLY_W) - 1;
   localparam int SPAN    = BASE_TICKS + DLY_MAX * STEP_TICKS;
   localparam int CNT_W   = $clog2(SPAN + 1);

   initial begin : param_chk
      assert (DLY_W >= 1 && DLY_W <= 8) else $error("DLY_W out of range");
      assert (BASE_TICKS >= 1) else $error("BASE_TICKS must keep a dead window");
      assert (STEP_TICKS >= 1) else $error("STEP_TICKS must be positive");
   end

   dt_state_e         state, nxt;
   logic              load, done, seen, hit, ld_dir;
   logic [NUM_WIN-1:0] upd;
   logic [DLY_W-1:0]  dly     [NUM_WIN];
   logic [CNT_W-1:0]  win_len [NUM_WIN];
   logic [CNT_W-1:0]  load_val;

   assign hit = seen | diode_sense;

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      dt_delay_reg #(.DLY_W(DLY_W)) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .upd   (upd[g]),
         .hit   (hit),
         .val   (dly[g])
      );
      if (STEP_TICKS == 1) begin : g_unit
         assign win_len[g] = CNT_W'(BASE_TICKS) + CNT_W'(dly[g]);
      end else begin : g_scaled
         assign win_len[g] = CNT_W'(BASE_TICKS + int'(dly[g]) * STEP_TICKS);
      end
   end

   assign load_val = win_len[ld_dir] - CNT_W'(1);

   dt_window_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .done     (done)
   );

   always_comb begin
      nxt    = state;
      load   = 1'b0;
      ld_dir = 1'b0;
      upd    = '0;
      if (!en) begin
         nxt = ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE: nxt = pwm_req ? ST_HS : ST_LS;
            ST_HS: if (!pwm_req) begin
               nxt    = ST_HL;
               load   = 1'b1;
               ld_dir = 1'(WIN_HL);
            end
            ST_LS: if (pwm_req) begin
               nxt    = ST_LH;
               load   = 1'b1;
               ld_dir = 1'(WIN_LH);
            end
            ST_HL: if (done) begin
               nxt         = ST_LS;
               upd[WIN_HL] = 1'b1;
            end
            ST_LH: if (done) begin
               nxt         = ST_HS;
               upd[WIN_LH] = 1'b1;
            end
            default: nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         seen  <= 1'b0;
         hs_on <= 1'b0;
         ls_on <= 1'b0;
      end else begin
         state <= nxt;
         hs_on <= (nxt == ST_HS);
         ls_on <= (nxt == ST_LS);
         if (load || !en)                        seen <= 1'b0;
         else if (state == ST_HL || state == ST_LH) seen <= hit;
      end
   end

   // R3
   no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_on && ls_on));

   // R2
   off_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !hs_on && !ls_on);

   // R4
   ls_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_on) |-> !$past(hs_on));

   // R5
   hs_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_on) |-> !$past(ls_on));

   // R10
   window_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && state == ST_HL |=> !hs_on);

endmodule

// File: tb/tb_dt_predictive_ctrl.sv
`timescale 1ns/1ps
module tb_dt_predictive_ctrl;

   localparam int W    = 4;
   localparam int BASE = 1;
   localparam int STEP = 1;
   localparam int DMAX = (1 << W) - 1;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, pwm_req = 1'b0, diode_sense = 1'b0;
   logic hs_on, ls_on;

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dt_predictive_ctrl #(.DLY_W(W), .BASE_TICKS(BASE), .STEP_TICKS(STEP)) dut (
      .clk(clk), .rst_n(rst_n), .en(en), .pwm_req(pwm_req),
      .diode_sense(diode_sense), .hs_on(hs_on), .ls_on(ls_on)
   );

   // behavioural reference: phase 0 off, 1 main on, 2 main-off gap, 3 rect on, 4 rect-off gap
   int ph = 0, left = 0;
   bit saw = 1'b0;
   int setting [2];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph = 0; left = 0; saw = 1'b0;
         setting[0] = DMAX; setting[1] = DMAX;
      end else if (!en) begin
         ph = 0; saw = 1'b0;
      end else begin
         case (ph)
            0: ph = pwm_req ? 1 : 3;
            1: if (!pwm_req) begin ph = 2; left = BASE + setting[0] * STEP; saw = 1'b0; end
            3: if (pwm_req)  begin ph = 4; left = BASE + setting[1] * STEP; saw = 1'b0; end
            default: begin
               int k;
               k = (ph == 2) ? 0 : 1;
               saw = saw | diode_sense;
               left = left - 1;
               if (left == 0) begin
                  if (saw) setting[k] = (setting[k] > 0) ? setting[k] - 1 : 0;
                  else     setting[k] = (setting[k] < DMAX) ? setting[k] + 1 : DMAX;
                  ph = (ph == 2) ? 3 : 1;
               end
            end
         endcase
      end
   end

   function automatic string phase_tag(int p, logic e);
      if (!e)     return "R2";
      if (p == 2) return "R4";
      if (p == 4) return "R5";
      return "R10";
   endfunction

   always @(posedge clk) begin
      #1;
      if (rst_n && !finished) begin
         checks++;
         if (hs_on !== (ph == 1) || ls_on !== (ph == 3)) begin
            errors++;
            $display("FAIL %s model: hs_on=%b ls_on=%b expected hs_on=%b ls_on=%b at %0t",
                     phase_tag(ph, en), hs_on, ls_on, ph == 1, ph == 3, $time);
         end
         checks++;
         if (hs_on && ls_on) begin
            errors++;
            $display("FAIL R3 overlap: hs_on=1 ls_on=1 expected not both at %0t", $time);
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // change the request and time the dead gap until the selected switch is on
   task automatic step(input bit newpwm, input bit snc, input int exp_gap, input string tag);
      int edges;
      @(negedge clk);
      pwm_req = newpwm;
      diode_sense = snc;
      edges = 0;
      do begin
         @(posedge clk); #1;
         edges++;
      end while (!(newpwm ? hs_on : ls_on) && edges < 100);
      diode_sense = 1'b0;
      check(edges - 1 == exp_gap, tag, edges - 1, exp_gap);
   endtask

   initial begin : watchdog
      #(4 * 20000);
      if (!finished) begin
         finished = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check(hs_on == 1'b0 && ls_on == 1'b0, "R1 reset outputs", {hs_on, ls_on}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(hs_on == 1'b0 && ls_on == 1'b0, "R1 idle after reset", {hs_on, ls_on}, 0);

      en = 1'b1; pwm_req = 1'b1;
      @(posedge clk); #1;
      check(hs_on == 1'b1, "R10 direct start main", hs_on, 1);

      step(0, 0, 16, "R1 first main-off gap");
      step(1, 0, 16, "R1 first rect-off gap");
      step(0, 0, 16, "R8 ceiling held");
      step(1, 0, 16, "R9 other window");

      for (int i = 0; i < 16; i++) begin
         step(0, 1, 16 - i, "R6 shrink main-off");
         step(1, 0, 16, "R9 rect-off untouched");
      end
      step(0, 1, 1, "R8 floor held, R3 minimum gap");
      step(1, 1, 16, "R6 rect-off flagged");
      step(0, 0, 1, "R7 main-off grows from floor");
      step(1, 0, 15, "R6 rect-off shrunk");
      step(0, 0, 2, "R7 main-off grows again");
      step(1, 0, 16, "R7 rect-off grows");

      // disable while main switch on
      @(negedge clk); en = 1'b0;
      for (int i = 0; i < 5; i++) begin
         @(posedge clk); #1;
         check(hs_on == 1'b0 && ls_on == 1'b0, "R2 disabled low", {hs_on, ls_on}, 0);
         @(negedge clk); pwm_req = ~pwm_req;
      end
      @(negedge clk); pwm_req = 1'b1; en = 1'b1;
      @(posedge clk); #1;
      check(hs_on == 1'b1, "R10 restart main", hs_on, 1);

      // abort a main-off window (setting 2, 3 cycles) with the diode flagged
      @(negedge clk); pwm_req = 1'b0; diode_sense = 1'b1;
      @(negedge clk);
      @(negedge clk); en = 1'b0;
      @(posedge clk); #1;
      check(hs_on == 1'b0 && ls_on == 1'b0, "R2 abort low", {hs_on, ls_on}, 0);
      diode_sense = 1'b0;
      @(negedge clk); en = 1'b1; pwm_req = 1'b1;
      @(posedge clk); #1;
      check(hs_on == 1'b1, "R10 restart after abort", hs_on, 1);
      step(0, 0, 3, "R2 aborted window kept setting");
      step(1, 0, 16, "R5 rect-off gap");

      // request returns inside the main-off window (setting 3, 4 cycles)
      begin
         int ls_cycles, hs_seen;
         ls_cycles = 0; hs_seen = 0;
         @(negedge clk); pwm_req = 1'b0;
         @(negedge clk); pwm_req = 1'b1;
         for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            if (ls_on) ls_cycles++;
            if (hs_on) hs_seen = 1;
         end
         check(ls_cycles == 1, "R10 window completes, one rect cycle", ls_cycles, 1);
         check(hs_seen == 1, "R10 main back on", hs_seen, 1);
      end

      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule